// File: doc/BRIEF.md
# Serial Bus Clock Generator with Data-Launch Strobe

This block derives the clock line of a two-wire serial bus from a faster parent clock and tells the data shifter when it may change the data line. The clock rate comes from an 8-bit divider field. Each low and each high phase of the serial clock lasts divider+1 parent cycles, so the bus clock is parent/(2*(divider+1)) with a 50% duty cycle. After each falling edge of the serial clock, the block waits a number of parent cycles set by a 3-bit delay field and then raises a one-cycle launch strobe. The shifter uses that strobe to update the data line well away from the clock edge.

Both fields sit in a clock-control word. A second word gives manual control of each line and reads back the live line levels from the pads. Manual control of a line takes priority over the generated clock and over the shifter's data. While no transfer is running, the generated clock rests high and the divider counter rests at zero. The reset divider value is derived from the parent frequency and a target bus rate of 3 MHz. Elaboration fails if the target rate or the reset rate would exceed the 20 MHz bus limit.

Top module: `sbus_clkgen`

## Requirements
- R1: After reset, with the default parameters (250 MHz parent, 3 MHz target), the clock-control word reads 0x728 (divider 40, delay 7). The line word reads 0x30: all four control bits are zero and both pads are idle high.
- R2: Word address 0 is clock control: divider in bits 7:0 and SDA launch delay in bits 10:8. Word address 1 is line control: bit 0 enables manual SDA, bit 1 is the manual SDA level, bit 2 enables manual SCL, bit 3 is the manual SCL level. Bit 4 reads the live SDA level and bit 5 reads the live SCL level. A write takes effect on the clock edge that samples it.
- R3: While `run` is low, the generated clock is high, the divider counter is zero and `sda_upd` stays low, from the first edge that samples `run` low.
- R4: With `run` high, the first SCL fall comes divider+1 parent edges after the first edge that samples `run` high. Every later low and high phase lasts divider+1 parent cycles.
- R5: After the edge on which SCL falls, `sda_upd` is high for exactly one cycle, D edges later, where D is the delay field.
- R6: A delay field of zero behaves as a delay of one.
- R7: With manual SCL enabled, `scl_o` equals the manual SCL level from the edge that writes it, whether or not a transfer is running.
- R8: With manual SDA enabled, `sda_o` equals the manual SDA level. Otherwise `sda_o` follows `sda_data`.
- R9: Bits 5:4 of the line word show `scl_i` and `sda_i` through a synchronizer of SYNC_STAGES flops (2 by default), so a pad change is visible after two edges.
- R10: If the divider is written below the current count while running, SCL toggles on the very next edge instead of stalling.
- R11: Writes to the read-only live bits 5:4 of the line word have no effect on what those bits read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transfer active; enables clock generation |
| sda_data | input | 1 | Data level from the shifter |
| scl_i | input | 1 | Clock line level sensed at the pad |
| sda_i | input | 1 | Data line level sensed at the pad |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Word select: 0 clock control, 1 line control |
| cfg_wdata | input | 11 | Configuration write data |
| cfg_rdata | output | 11 | Read data for the selected word |
| scl_o | output | 1 | Clock line drive level |
| sda_o | output | 1 | Data line drive level |
| sda_upd | output | 1 | One-cycle data-launch strobe |

## Verification
A divider counter that misses its terminal value or overshoots it shows up as a wrong phase length on `scl_o`. The error is visible within one half-period of about divider+1 cycles and, if the counter runs away, as a stalled clock line. A wrong delay count or reload shows as `sda_upd` arriving on the wrong cycle after the fall, lasting two cycles, or never arriving; the bench finds this within seven cycles of a fall. A manual-select or synchronizer fault shows up on the line outputs or on the read-back bits within one to two edges of the write or the pad change.

// File: rtl/sbus_clk_pkg.sv
package sbus_clk_pkg;

   // word addresses of the two configuration words
   localparam logic ADDR_CLK  = 1'b0;
   localparam logic ADDR_LINE = 1'b1;

   // bit positions inside the line-control word
   localparam int LC_SDA_EN   = 0;
   localparam int LC_SDA_LVL  = 1;
   localparam int LC_SCL_EN   = 2;
   localparam int LC_SCL_LVL  = 3;
   localparam int LC_SDA_LIVE = 4;
   localparam int LC_SCL_LIVE = 5;
   localparam int LC_W        = 6;

   // writable line-control bits; bit 0 is sda_en
   typedef struct packed {
      logic scl_lvl;
      logic scl_en;
      logic sda_lvl;
      logic sda_en;
   } line_ctl_t;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction

endpackage

// File: rtl/sbus_cfg_regs.sv
module sbus_cfg_regs
   import sbus_clk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int DLY_W   = 3,
   parameter int RST_DIV = 40,
   parameter int RST_DLY = 7,
   localparam int FIELD_W = DIV_W + DLY_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               addr,
   input  logic [FIELD_W-1:0] wdata,
   input  logic               live_sda,
   input  logic               live_scl,
   output logic [DIV_W-1:0]   div_q,
   output logic [DLY_W-1:0]   dly_q,
   output line_ctl_t          line_q,
   output logic [FIELD_W-1:0] rdata
);

   localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RST_DIV);
   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(RST_DLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_INIT;
         dly_q  <= DLY_INIT;
         line_q <= '0;
      end else if (we) begin
         if (addr == ADDR_CLK) begin
            div_q <= wdata[DIV_W-1:0];
            dly_q <= wdata[DIV_W +: DLY_W];
         end else begin
            line_q <= line_ctl_t'(wdata[3:0]);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_CLK) begin
         rdata[DIV_W-1:0]     = div_q;
         rdata[DIV_W +: DLY_W] = dly_q;
      end else begin
         rdata[3:0]         = line_q;
         rdata[LC_SDA_LIVE] = live_sda;
         rdata[LC_SCL_LIVE] = live_scl;
      end
   end

endmodule

// File: rtl/sbus_sclk_div.sv
module sbus_sclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             scl_gen,
   output logic [DIV_W-1:0] cnt,
   output logic             fall_now
);

   logic at_end;

   // >= rather than == so a divider lowered mid-phase ends the phase at once
   assign at_end   = (cnt >= div);
   assign fall_now = run && at_end && scl_gen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         scl_gen <= 1'b1;
      end else if (!run) begin
         cnt     <= '0;
         scl_gen <= 1'b1;
      end else if (at_end) begin
         cnt     <= '0;
         scl_gen <= ~scl_gen;
      end else begin
         cnt     <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sbus_launch_dly.sv
module sbus_launch_dly #(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fall_now,
   input  logic [DLY_W-1:0] dly,
   output logic             strobe
);

   logic [DLY_W-1:0] dcnt;
   logic [DLY_W-1:0] dly_eff;

   // a zero delay would collide with the clock edge itself
   assign dly_eff = (dly == '0) ? DLY_W'(1) : dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         strobe <= 1'b0;
      end else if (!run) begin
         dcnt   <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= (dcnt == DLY_W'(1));
         if (fall_now)
            dcnt <= dly_eff;
         else if (dcnt != '0)
            dcnt <= dcnt - 1'b1;
      end
   end

endmodule

// File: rtl/sbus_line_mux.sv
module sbus_line_mux
   import sbus_clk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_ctl_t line_q,
   input  logic      scl_gen,
   input  logic      sda_data,
   input  logic      scl_i,
   input  logic      sda_i,
   output logic      scl_o,
   output logic      sda_o,
   output logic      live_scl,
   output logic      live_sda
);

   assign scl_o = line_q.scl_en ? line_q.scl_lvl : scl_gen;
   assign sda_o = line_q.sda_en ? line_q.sda_lvl : sda_data;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign live_scl = scl_i;
         assign live_sda = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_sh;
         logic [SYNC_STAGES-1:0] sda_sh;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[s] <= 1'b1;
                  sda_sh[s] <= 1'b1;
               end else if (s == 0) begin
                  scl_sh[s] <= scl_i;
                  sda_sh[s] <= sda_i;
               end else begin
                  scl_sh[s] <= scl_sh[(s == 0) ? 0 : s-1];
                  sda_sh[s] <= sda_sh[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign live_scl = scl_sh[SYNC_STAGES-1];
         assign live_sda = sda_sh[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sbus_clkgen.sv
module sbus_clkgen
   import sbus_clk_pkg::*;
#(
   parameter int PARENT_HZ   = 250_000_000,
   parameter int TARGET_HZ   = 3_000_000,
   parameter int MAX_BUS_HZ  = 20_000_000,
   parameter int DIV_W       = 8,
   parameter int DLY_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int FIELD_W    = DIV_W + DLY_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               sda_data,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic               cfg_we,
   input  logic               cfg_addr,
   input  logic [FIELD_W-1:0] cfg_wdata,
   output logic [FIELD_W-1:0] cfg_rdata,
   output logic               scl_o,
   output logic               sda_o,
   output logic               sda_upd
);

   // reset divider from the target rate: parent / target / 2, clamped
   localparam int RAW_DIV_P1 = PARENT_HZ / TARGET_HZ / 2;
   localparam int RST_DIV_P1 = clamp_int(RAW_DIV_P1, 1, 2**DIV_W);
   localparam int RST_DIV    = RST_DIV_P1 - 1;
   localparam int RST_DLY    = clamp_int(RST_DIV_P1 >> 1, 1, 2**DLY_W - 1);
   localparam int RST_BUS_HZ = PARENT_HZ / (2 * RST_DIV_P1);

   generate
      if (TARGET_HZ > MAX_BUS_HZ) begin : g_err_target
         $error("target bus rate above the bus limit");
      end
      if (RST_BUS_HZ > MAX_BUS_HZ) begin : g_err_reset
         $error("reset divider yields a bus rate above the limit");
      end
      if (FIELD_W < LC_W) begin : g_err_width
         $error("configuration word too narrow for line control");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_err_sync
         $error("SYNC_STAGES out of range 0..4");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DLY_W-1:0] dly_q;
   line_ctl_t        line_q;
   logic             live_scl;
   logic             live_sda;
   logic             scl_gen;
   logic [DIV_W-1:0] div_cnt;
   logic             fall_now;

   sbus_cfg_regs #(
      .DIV_W   (DIV_W),
      .DLY_W   (DLY_W),
      .RST_DIV (RST_DIV),
      .RST_DLY (RST_DLY)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .live_sda (live_sda),
      .live_scl (live_scl),
      .div_q    (div_q),
      .dly_q    (dly_q),
      .line_q   (line_q),
      .rdata    (cfg_rdata)
   );

   sbus_sclk_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div      (div_q),
      .scl_gen  (scl_gen),
      .cnt      (div_cnt),
      .fall_now (fall_now)
   );

   sbus_launch_dly #(
      .DLY_W (DLY_W)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .fall_now (fall_now),
      .dly      (dly_q),
      .strobe   (sda_upd)
   );

   sbus_line_mux #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_q   (line_q),
      .scl_gen  (scl_gen),
      .sda_data (sda_data),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_o    (scl_o),
      .sda_o    (sda_o),
      .live_scl (live_scl),
      .live_sda (live_sda)
   );

endmodule

// File: rtl/sbus_clkgen_chk.sv
module sbus_clkgen_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cfg_we,
   input logic             cfg_addr,
   input logic [3:0]       wr_line,
   input logic             scl_o,
   input logic             sda_o,
   input logic             sda_upd,
   input logic             scl_gen,
   input logic [DIV_W-1:0] div_cnt
);

   assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (scl_gen && div_cnt == '0));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sda_upd);

   assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && div_cnt != '0) |-> $stable(scl_gen));

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_upd |=> !sda_upd);

   assert_manual_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr && wr_line[2]) |=> (scl_o == $past(wr_line[3])));

   assert_manual_sda_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr && wr_line[0]) |=> (sda_o == $past(wr_line[1])));

endmodule

bind sbus_clkgen sbus_clkgen_chk #(.DIV_W(8)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .cfg_we  (cfg_we),
   .cfg_addr(cfg_addr),
   .wr_line (cfg_wdata[3:0]),
   .scl_o   (scl_o),
   .sda_o   (sda_o),
   .sda_upd (sda_upd),
   .scl_gen (scl_gen),
   .div_cnt (div_cnt)
);

// File: tb/sbus_clkgen_tb.sv
`timescale 1ns/1ps
module sbus_clkgen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        run;
   logic        sda_data;
   logic        scl_i;
   logic        sda_i;
   logic        cfg_we;
   logic        cfg_addr;
   logic [10:0] cfg_wdata;
   logic [10:0] cfg_rdata;
   logic        scl_o;
   logic        sda_o;
   logic        sda_upd;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   always #2 clk = ~clk;

   sbus_clkgen u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sda_data (sda_data),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .scl_o    (scl_o),
      .sda_o    (sda_o),
      .sda_upd  (sda_upd)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL R4 watchdog: actual %0d cycles expected < 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [10:0] d);
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      tick();
      cfg_we    = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [10:0] v);
      cfg_addr = a;
      #0.5;
      v = cfg_rdata;
   endtask

   task automatic wait_scl(input logic lvl, output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (scl_o != lvl && n < 600);
   endtask

   task automatic t_reset();
      logic [10:0] v;
      rd(1'b0, v);
      check("R1 clock word reset", int'(v), 'h728);
      rd(1'b1, v);
      check("R1 line word reset", int'(v), 'h30);
      check("R3 scl idle after reset", int'(scl_o), 1);
   endtask

   task automatic t_fields();
      logic [10:0] v;
      wr(1'b0, 11'h5A3);
      rd(1'b0, v);
      check("R2 clock word layout", int'(v), 'h5A3);
      wr(1'b1, 11'h7F0);
      rd(1'b1, v);
      check("R11 live bits unaffected by write", int'(v), 'h30);
      wr(1'b1, 11'h000);
   endtask

   task automatic t_period(input int div, input int dly);
      int n;
      int eff;
      eff = (dly == 0) ? 1 : dly;
      wr(1'b0, 11'((dly << 8) | div));
      run = 1'b1;
      wait_scl(1'b0, n);
      check($sformatf("R4 first fall div=%0d", div), n, div + 1);
      n = 0;
      do begin
         tick();
         n++;
      end while (!sda_upd && n < 20);
      check($sformatf("R5 R6 strobe delay dly=%0d", dly), n, eff);
      tick();
      check("R5 strobe one cycle wide", int'(sda_upd), 0);
      if (scl_o == 1'b0) wait_scl(1'b1, n);
      wait_scl(1'b0, n);
      wait_scl(1'b1, n);
      check($sformatf("R4 low phase div=%0d", div), n, div + 1);
      wait_scl(1'b0, n);
      check($sformatf("R4 high phase div=%0d", div), n, div + 1);
      run = 1'b0;
      tick();
      check("R3 scl high after run drops", int'(scl_o), 1);
      check("R3 no strobe after run drops", int'(sda_upd), 0);
      repeat (8) begin
         tick();
         if (sda_upd || !scl_o) check("R3 idle lines quiet", 1, 0);
      end
   endtask

   task automatic t_shrink();
      wr(1'b0, 11'h114);
      run = 1'b1;
      repeat (10) tick();
      check("R10 still high mid phase", int'(scl_o), 1);
      wr(1'b0, 11'h103);
      check("R10 no toggle on write edge", int'(scl_o), 1);
      tick();
      check("R10 toggle right after shrink", int'(scl_o), 0);
      run = 1'b0;
      tick();
   endtask

   task automatic t_manual();
      wr(1'b1, 11'h004);
      check("R7 manual scl low", int'(scl_o), 0);
      wr(1'b1, 11'h00C);
      check("R7 manual scl high", int'(scl_o), 1);
      wr(1'b1, 11'h004);
      run = 1'b1;
      repeat (5) begin
         tick();
         if (scl_o) check("R7 manual wins while running", 1, 0);
      end
      run = 1'b0;
      sda_data = 1'b1;
      wr(1'b1, 11'h000);
      check("R8 sda follows data", int'(sda_o), 1);
      wr(1'b1, 11'h001);
      check("R8 manual sda low", int'(sda_o), 0);
      sda_data = 1'b0;
      wr(1'b1, 11'h003);
      check("R8 manual sda high", int'(sda_o), 1);
      wr(1'b1, 11'h000);
      check("R8 sda back to data", int'(sda_o), 0);
   endtask

   task automatic t_live();
      logic [10:0] v;
      sda_i = 1'b0;
      tick();
      rd(1'b1, v);
      check("R9 sda live after one edge", int'(v[4]), 1);
      tick();
      rd(1'b1, v);
      check("R9 sda live after two edges", int'(v[4]), 0);
      scl_i = 1'b0;
      tick();
      tick();
      rd(1'b1, v);
      check("R9 scl live after two edges", int'(v[5]), 0);
      sda_i = 1'b1;
      scl_i = 1'b1;
      tick();
      tick();
   endtask

   initial begin
      rst_n     = 1'b0;
      run       = 1'b0;
      sda_data  = 1'b0;
      scl_i     = 1'b1;
      sda_i     = 1'b1;
      cfg_we    = 1'b0;
      cfg_addr  = 1'b0;
      cfg_wdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_fields();
      t_period(0, 1);
      t_period(3, 0);
      t_period(5, 7);
      t_period(2, 3);
      t_shrink();
      t_manual();
      t_live();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule